// File: doc/BRIEF.md
# Bidirectional Universal Shift Register with Shared Data Port

The block is a register of configurable width (eight stages by default). On each rising clock edge it keeps its contents, moves them one stage toward the high end, moves them one stage toward the low end, or captures a whole word. Two select inputs choose between these four operations. An active-low clear, sampled only on the clock edge, takes priority over every other input and empties all stages. Each end of the chain has a serial input: the low-end input feeds stage 0 when shifting toward the high end, and the high-end input feeds the top stage when shifting toward the low end.

One data port carries the parallel input and the parallel output. Inside the chip it is split into a pad input, a pad output and a pad output-enable. The enable is formed combinationally from the select inputs and two active-low output enables. It is cleared whenever the word-capture operation is selected, so that outside logic can drive the port, and it is also cleared when either output enable is high. The output enables only steer the port and never change the register. Two serial taps show the lowest and highest stages at all times, including while the port is released.

Top module: `ushift_reg`

## Requirements
- R1: When `clr_n` is low at a rising clock edge, every stage becomes 0, whatever the select, enable, serial and pad inputs are. This includes the word-capture selection with nonzero pad data.
- R2: With `clr_n` high and {`sel_hi`,`sel_lo`} = 2'b00, the stored word is unchanged after the edge.
- R3: With {`sel_hi`,`sel_lo`} = 2'b01, stage 0 takes `ser_in_lo` and stage i takes the old stage i-1, so the new word is {old[W-2:0], ser_in_lo}.
- R4: With {`sel_hi`,`sel_lo`} = 2'b10, the top stage takes `ser_in_hi` and stage i takes the old stage i+1, so the new word is {ser_in_hi, old[W-1:1]}.
- R5: With {`sel_hi`,`sel_lo`} = 2'b11, the word on `pad_in` is stored at the edge, with bit i going to stage i.
- R6: `pad_oe` is 1 only when `oe_a_n` and `oe_b_n` are both 0 and the selection is not 2'b11. It follows its inputs within the same cycle, with no clock edge in between.
- R7: `oe_a_n` and `oe_b_n` have no effect on the stored word. Shifting, holding, capturing and clearing give the same result while the port is released.
- R8: `tap_lo` always equals stage 0 and `tap_hi` always equals the top stage, whatever the state of `pad_oe`. Both are 0 after a clear.
- R9: `pad_out` carries the stored word, bit i from stage i, so the port shows that word whenever `pad_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| sel_lo | input | 1 | Operation select, low bit |
| sel_hi | input | 1 | Operation select, high bit |
| oe_a_n | input | 1 | First port enable, active low |
| oe_b_n | input | 1 | Second port enable, active low |
| ser_in_lo | input | 1 | Serial input into stage 0 when shifting upward |
| ser_in_hi | input | 1 | Serial input into the top stage when shifting downward |
| pad_in | input | WIDTH | Word read from the shared port |
| pad_out | output | WIDTH | Word driven onto the shared port |
| pad_oe | output | 1 | Drive enable for the shared port |
| tap_lo | output | 1 | Stage 0, always driven |
| tap_hi | output | 1 | Top stage, always driven |

## Verification
The bench applies a clear while word capture is selected and all-ones data sits on the port. A design that gave capture priority over clear would keep that data instead of zeros. On every cycle the bench checks that the port is never driven by both sides, and it tests that `pad_oe` drops in the same cycle that capture is selected. A registered enable would cause contention for one cycle. Shifts in both directions start from asymmetric words and use both values of the serial inputs, which exposes a reversed direction or a serial input fed to the wrong end. Shifts and captures with the port released, checked later by reading the word back, catch a design that gates sequential operation on the enables.

// File: rtl/ushift_pkg.sv
package ushift_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'b00,
        MODE_RIGHT = 2'b01,
        MODE_LEFT  = 2'b10,
        MODE_LOAD  = 2'b11
    } mode_e;
endpackage

// File: rtl/ushift_mode_dec.sv
module ushift_mode_dec
    import ushift_pkg::*;
(
    input  logic  sel_hi,
    input  logic  sel_lo,
    output mode_e mode
);
    always_comb begin
        mode = mode_e'({sel_hi, sel_lo});
    end
endmodule

// File: rtl/ushift_cell.sv
module ushift_cell
    import ushift_pkg::*;
(
    input  mode_e mode,
    input  logic  cur,
    input  logic  from_lower,
    input  logic  from_upper,
    input  logic  pad_bit,
    output logic  nxt
);
    always_comb begin
        unique case (mode)
            MODE_HOLD:  nxt = cur;
            MODE_RIGHT: nxt = from_lower;
            MODE_LEFT:  nxt = from_upper;
            MODE_LOAD:  nxt = pad_bit;
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/ushift_pad_ctl.sv
module ushift_pad_ctl
    import ushift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  mode_e             mode,
    input  logic              oe_a_n,
    input  logic              oe_b_n,
    input  logic [WIDTH-1:0]  word,
    output logic [WIDTH-1:0]  pad_out,
    output logic              pad_oe
);
    logic enables_on;

    always_comb begin
        enables_on = ~(oe_a_n | oe_b_n);
        pad_oe     = enables_on && (mode != MODE_LOAD);
        pad_out    = word;
    end
endmodule

// File: rtl/ushift_reg.sv
module ushift_reg
    import ushift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              sel_lo,
    input  logic              sel_hi,
    input  logic              oe_a_n,
    input  logic              oe_b_n,
    input  logic              ser_in_lo,
    input  logic              ser_in_hi,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic              pad_oe,
    output logic              tap_lo,
    output logic              tap_hi
);
    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } state_t;

    state_t            st_d;
    state_t            st_q;
    mode_e             mode;
    logic [WIDTH-1:0]  cell_nxt;
    logic [WIDTH-1:0]  lower_v;
    logic [WIDTH-1:0]  upper_v;

    ushift_mode_dec u_dec (
        .sel_hi (sel_hi),
        .sel_lo (sel_lo),
        .mode   (mode)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == 0) begin : g_low_end
            assign lower_v[i] = ser_in_lo;
        end else begin : g_low_mid
            assign lower_v[i] = st_q.word[i-1];
        end
        if (i == TOP) begin : g_high_end
            assign upper_v[i] = ser_in_hi;
        end else begin : g_high_mid
            assign upper_v[i] = st_q.word[i+1];
        end

        ushift_cell u_cell (
            .mode       (mode),
            .cur        (st_q.word[i]),
            .from_lower (lower_v[i]),
            .from_upper (upper_v[i]),
            .pad_bit    (pad_in[i]),
            .nxt        (cell_nxt[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (!clr_n) begin
            st_d.word = '0;
        end else begin
            st_d.word = cell_nxt;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    ushift_pad_ctl #(.WIDTH(WIDTH)) u_pad (
        .mode    (mode),
        .oe_a_n  (oe_a_n),
        .oe_b_n  (oe_b_n),
        .word    (st_q.word),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    assign tap_lo = st_q.word[0];
    assign tap_hi = st_q.word[TOP];
endmodule

// File: rtl/ushift_chk.sv
module ushift_chk #(
    parameter int WIDTH = 8
) (
    input logic              clk,
    input logic              clr_n,
    input logic              sel_lo,
    input logic              sel_hi,
    input logic              oe_a_n,
    input logic              oe_b_n,
    input logic              ser_in_lo,
    input logic              ser_in_hi,
    input logic [WIDTH-1:0]  pad_in,
    input logic [WIDTH-1:0]  pad_out,
    input logic              pad_oe,
    input logic              tap_lo,
    input logic              tap_hi
);
    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        if (!clr_n) armed <= 1'b1;
    end

    // R1
    clear_zero_chk: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |=> (pad_out == '0));

    // R2
    hold_keep_chk: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && !sel_hi && !sel_lo) |=> $stable(pad_out));

    // R3
    shift_up_chk: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && !sel_hi && sel_lo) |=>
        (pad_out == {$past(pad_out[WIDTH-2:0]), $past(ser_in_lo)}));

    // R4
    shift_down_chk: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && sel_hi && !sel_lo) |=>
        (pad_out == {$past(ser_in_hi), $past(pad_out[WIDTH-1:1])}));

    // R5
    capture_chk: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && sel_hi && sel_lo) |=> (pad_out == $past(pad_in)));

    // R6
    load_release_chk: assert property (@(posedge clk) disable iff (!armed)
        (sel_hi && sel_lo) |-> !pad_oe);

    // R6
    enable_release_chk: assert property (@(posedge clk) disable iff (!armed)
        (oe_a_n || oe_b_n) |-> !pad_oe);

    // R8
    taps_chk: assert property (@(posedge clk) disable iff (!armed)
        (tap_lo == pad_out[0]) && (tap_hi == pad_out[WIDTH-1]));
endmodule

bind ushift_reg ushift_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_ushift_reg.sv
module sim_ushift_reg;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic         sel_lo = 1'b0;
    logic         sel_hi = 1'b0;
    logic         oe_a_n = 1'b0;
    logic         oe_b_n = 1'b0;
    logic         ser_in_lo = 1'b0;
    logic         ser_in_hi = 1'b0;
    logic         ext_en = 1'b0;
    logic [W-1:0] ext_val = '0;
    logic [W-1:0] pad_in;
    logic [W-1:0] pad_out;
    logic         pad_oe;
    logic         tap_lo;
    logic         tap_hi;
    logic [W-1:0] model = '0;
    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    assign pad_in = ext_en ? ext_val : pad_out;

    ushift_reg #(.WIDTH(W)) u0 (
        .clk(clk), .clr_n(clr_n), .sel_lo(sel_lo), .sel_hi(sel_hi),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .ser_in_lo(ser_in_lo),
        .ser_in_hi(ser_in_hi), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .tap_lo(tap_lo), .tap_hi(tap_hi)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // contention monitor (R6): bench drives only while the block releases
    always @(negedge clk) begin
        if (clr_n === 1'b1 || clr_n === 1'b0) begin
            if (ext_en && pad_oe) begin
                errors++;
                $display("FAIL R6: contention actual pad_oe=1 expected 0 at %0t", $time);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic set_mode(input logic hi, input logic lo);
        sel_hi = hi;
        sel_lo = lo;
        ext_en = hi && lo;
    endtask

    task automatic read_word(input string req);
        set_mode(1'b0, 1'b0);
        oe_a_n = 1'b0;
        oe_b_n = 1'b0;
        #1;
        check(req, {7'd0, pad_oe}, 8'd1);
        check(req, pad_out, model);
        check("R8", {6'd0, tap_hi, tap_lo}, {6'd0, model[W-1], model[0]});
    endtask

    task automatic t_reset();
        clr_n = 1'b0;
        set_mode(1'b0, 1'b0);
        tick();
        tick();
        model = '0;
        clr_n = 1'b1;
        read_word("R1");
    endtask

    task automatic t_load(input logic [W-1:0] v);
        set_mode(1'b1, 1'b1);
        ext_val = v;
        #1;
        check("R6", {7'd0, pad_oe}, 8'd0);
        tick();
        model = v;
        read_word("R5");
    endtask

    task automatic t_hold(input int n);
        set_mode(1'b0, 1'b0);
        for (int i = 0; i < n; i++) tick();
        read_word("R2");
    endtask

    task automatic t_right(input logic s);
        set_mode(1'b0, 1'b1);
        ser_in_lo = s;
        ser_in_hi = ~s;
        tick();
        model = {model[W-2:0], s};
        read_word("R3");
    endtask

    task automatic t_left(input logic s);
        set_mode(1'b1, 1'b0);
        ser_in_hi = s;
        ser_in_lo = ~s;
        tick();
        model = {s, model[W-1:1]};
        read_word("R4");
    endtask

    task automatic t_released();
        oe_a_n = 1'b1;
        set_mode(1'b0, 1'b1);
        ser_in_lo = 1'b1;
        #1;
        check("R6", {7'd0, pad_oe}, 8'd0);
        tick();
        model = {model[W-2:0], 1'b1};
        check("R8", {6'd0, tap_hi, tap_lo}, {6'd0, model[W-1], model[0]});
        oe_a_n = 1'b0;
        oe_b_n = 1'b1;
        #1;
        check("R6", {7'd0, pad_oe}, 8'd0);
        set_mode(1'b1, 1'b1);
        ext_val = 8'h3C;
        tick();
        model = 8'h3C;
        set_mode(1'b0, 1'b0);
        tick();
        read_word("R7");
    endtask

    task automatic t_clear_over_load();
        set_mode(1'b1, 1'b1);
        ext_val = 8'hFF;
        clr_n = 1'b0;
        #1;
        check("R6", {7'd0, pad_oe}, 8'd0);
        tick();
        model = '0;
        check("R1", {6'd0, tap_hi, tap_lo}, 8'd0);
        clr_n = 1'b1;
        read_word("R1");
    endtask

    initial begin
        #2;
        t_reset();
        t_load(8'hA5);
        check("R9", pad_out, 8'hA5);
        t_hold(3);
        t_right(1'b1);
        check("R3", pad_out, 8'h4B);
        t_right(1'b0);
        check("R3", pad_out, 8'h96);
        t_left(1'b1);
        check("R4", pad_out, 8'hCB);
        t_left(1'b0);
        check("R4", pad_out, 8'h65);
        for (int i = 0; i < W; i++) t_left(1'b1);
        check("R4", pad_out, 8'hFF);
        t_released();
        t_load(8'h81);
        t_clear_over_load();
        t_hold(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule